// File: doc/BRIEF.md
# Single-Initiator Core Halt Controller

This block accepts halt requests from a set of agents, one request port per agent, and turns a permitted request into a write to the debug wrapper register of the target core. Each wrapper register is modelled inside the block. It holds a halt-request bit, a halted-acknowledge bit and a group of other writable control bits. The acknowledge bit follows a per-core input from the core being halted.

Only one agent may ever initiate halts. The first agent whose request passes the basic checks claims ownership. Ownership is held until reset, and requests from any other agent are turned away. The owner may halt any other core that has a debug base. It then either returns at once (zero timeout) or waits a programmable number of clock cycles for the acknowledge.

Every request produces a one-cycle done pulse on the requester's own port with a signed status code. The only exception is a request from the owner while one of its halts is still waiting; that request is ignored.

Top module: `core_halt_ctl`

## Requirements
- R1: Each result is a one-cycle pulse on `done[i]` of requester i, with a signed 4-bit code on `status[4*i+3:4*i]`. The codes are: 4'h0 success, 4'h1 target already halted, 4'hF target unsupported, 4'hE self-halt, 4'hD another agent owns halting, 4'hC halt timeout.
- R2: Each target's 32-bit wrapper word appears on `wrap_word[32*t+31:32*t]`. Bit 31 is the halt request and bit 28 is the acknowledge. Bit 28 equals `core_ack[t]` as sampled at the previous clock edge. After reset, the other bits hold `WRAP_RST` with bit 28 cleared. Once the halt bit has been set, it never clears.
- R3: A request for a target whose `DBG_PRESENT` bit is 0 (or whose index is N_CORE or above) returns 4'hF. It writes no wrapper word and claims no ownership.
- R4: A request whose target equals the requester's own index returns 4'hE. It writes no wrapper word and claims no ownership.
- R5: While no agent owns halting, the first request that passes R3 and R4 makes its requester the owner until reset. A later request from any other agent that passes R3 and R4 returns 4'hD. The owner may keep halting other cores.
- R6: When several requests that would claim ownership arrive in the same cycle, the lowest requester index becomes owner. The others in that cycle return 4'hD.
- R7: If the owner's target already shows its acknowledge bit, the result is 4'h1 and the wrapper word is not written.
- R8: A halt writes exactly 32'h8000_0000 to the target wrapper word. The halt bit is set and every other writable bit is cleared.
- R9: With a timeout value of 0, the success code is returned on the clock edge that samples the request.
- R10: With a nonzero timeout N, success is returned on the first edge at which the acknowledge bit of the target is seen. If no acknowledge is seen, 4'hC is returned N edges after the request edge.
- R11: A request from the owner while its own halt is still waiting for acknowledge produces no result and no write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | N_CORE | Request strobe, one per requesting agent |
| req_tgt | input | N_CORE*IDW | Target core index per agent |
| req_tmo | input | N_CORE*TMO_W | Acknowledge timeout in clock cycles per agent |
| core_ack | input | N_CORE | Halted indication from each core |
| done | output | N_CORE | One-cycle result pulse per agent |
| status | output | N_CORE*4 | Signed result code per agent |
| wrap_word | output | N_CORE*32 | Current wrapper register value per target |

## Verification
The bench builds the block with four cores and `DBG_PRESENT` = 4'b0111, so the highest core has no debug base and the unsupported path can be reached. `WRAP_RST` = 32'h0000_000F gives the wrapper words nonzero control bits after reset, so it is visible at the ports when a halt write clears them. Timeouts of 0, 5 and 20 cycles keep the exact timeout latency, a mid-wait acknowledge and the ignored owner request within a few dozen cycles. Two agents requesting together exercise the lowest-index claim rule.

// File: rtl/core_halt_pkg.sv
package core_halt_pkg;

  localparam int HALT_BIT = 31;
  localparam int ACK_BIT  = 28;
  localparam int WORD_W   = 32;
  localparam int CODE_W   = 4;

  localparam logic [WORD_W-1:0] HALT_ONLY = WORD_W'(1) << HALT_BIT;

  localparam logic [CODE_W-1:0] ST_OK      = 4'h0;
  localparam logic [CODE_W-1:0] ST_ALREADY = 4'h1;
  localparam logic [CODE_W-1:0] ST_UNSUP   = 4'hF;
  localparam logic [CODE_W-1:0] ST_SELF    = 4'hE;
  localparam logic [CODE_W-1:0] ST_OWNED   = 4'hD;
  localparam logic [CODE_W-1:0] ST_TMO     = 4'hC;

  typedef enum logic {S_IDLE, S_WAIT} seq_st_e;

endpackage

// File: rtl/halt_wrap_bank.sv
module halt_wrap_bank
  import core_halt_pkg::*;
#(
  parameter int              N_CORE   = 4,
  parameter int              IDW      = 3,
  parameter logic [WORD_W-1:0] WRAP_RST = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_CORE-1:0]        core_ack,
  input  logic                     wr_en,
  input  logic [IDW-1:0]           wr_idx,
  output logic [N_CORE-1:0]        ack_q,
  output logic [N_CORE*WORD_W-1:0] word
);

  localparam logic [WORD_W-1:0] ACK_MASK = WORD_W'(1) << ACK_BIT;
  localparam logic [WORD_W-1:0] RST_VAL  = WRAP_RST & ~ACK_MASK;

  genvar k;
  generate
    for (k = 0; k < N_CORE; k++) begin : g_reg
      logic [WORD_W-1:0] store_q;
      logic [WORD_W-1:0] store_d;
      logic              store_en;
      logic              ack_r;

      always_comb begin
        store_en = wr_en && (wr_idx == IDW'(k));
        store_d  = HALT_ONLY;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          store_q <= RST_VAL;
        end else if (store_en) begin
          store_q <= store_d;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ack_r <= 1'b0;
        end else begin
          ack_r <= core_ack[k];
        end
      end

      always_comb begin
        word[k*WORD_W +: WORD_W] = (store_q & ~ACK_MASK) | (ack_r ? ACK_MASK : '0);
        ack_q[k]                 = ack_r;
      end
    end
  endgenerate

endmodule

// File: rtl/halt_own_arb.sv
module halt_own_arb
  import core_halt_pkg::*;
#(
  parameter int                N_CORE      = 4,
  parameter int                IDW         = 3,
  parameter logic [N_CORE-1:0] DBG_PRESENT = '1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_CORE-1:0]        req_vld,
  input  logic [N_CORE*IDW-1:0]    req_tgt,
  input  logic                     busy,
  output logic [N_CORE-1:0]        grant,
  output logic [N_CORE-1:0]        rej_vld,
  output logic [N_CORE*CODE_W-1:0] rej_code,
  output logic [IDW-1:0]           own_id
);

  localparam int             SPAN    = 2 ** IDW;
  localparam logic [IDW-1:0] UNOWNED = '1;

  logic [SPAN-1:0]   present_ext;
  logic [N_CORE-1:0] unsup;
  logic [N_CORE-1:0] selfr;
  logic [N_CORE-1:0] elig;
  logic [IDW-1:0]    owner_q;
  logic [IDW-1:0]    owner_d;
  logic [IDW-1:0]    claim_id;
  logic [IDW-1:0]    eff_owner;
  logic              owned;
  logic              owner_en;

  always_comb present_ext = SPAN'(DBG_PRESENT);

  genvar i;
  generate
    for (i = 0; i < N_CORE; i++) begin : g_chk
      logic [IDW-1:0] tgt;
      always_comb begin
        tgt      = req_tgt[i*IDW +: IDW];
        unsup[i] = !present_ext[tgt];
        selfr[i] = (tgt == IDW'(i));
        elig[i]  = req_vld[i] && !unsup[i] && !selfr[i];
      end
    end
  endgenerate

  // lowest eligible index wins a fresh claim
  always_comb begin
    claim_id = UNOWNED;
    for (int j = N_CORE - 1; j >= 0; j--) begin
      if (elig[j]) claim_id = IDW'(j);
    end
  end

  always_comb begin
    owned     = (owner_q != UNOWNED);
    eff_owner = owned ? owner_q : claim_id;
    owner_en  = !owned && (|elig);
    owner_d   = claim_id;
  end

  always_comb begin
    grant    = '0;
    rej_vld  = '0;
    rej_code = '0;
    for (int j = 0; j < N_CORE; j++) begin
      if (req_vld[j] && !(busy && (owner_q == IDW'(j)))) begin
        if (unsup[j]) begin
          rej_vld[j]                  = 1'b1;
          rej_code[j*CODE_W +: CODE_W] = ST_UNSUP;
        end else if (selfr[j]) begin
          rej_vld[j]                  = 1'b1;
          rej_code[j*CODE_W +: CODE_W] = ST_SELF;
        end else if (eff_owner != IDW'(j)) begin
          rej_vld[j]                  = 1'b1;
          rej_code[j*CODE_W +: CODE_W] = ST_OWNED;
        end else begin
          grant[j] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= UNOWNED;
    end else if (owner_en) begin
      owner_q <= owner_d;
    end
  end

  always_comb own_id = owner_q;

endmodule

// File: rtl/halt_seq.sv
module halt_seq
  import core_halt_pkg::*;
#(
  parameter int N_CORE = 4,
  parameter int IDW    = 3,
  parameter int TMO_W  = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_CORE-1:0]       grant,
  input  logic [N_CORE*IDW-1:0]   req_tgt,
  input  logic [N_CORE*TMO_W-1:0] req_tmo,
  input  logic [N_CORE-1:0]       ack_q,
  output logic                    busy,
  output logic                    wr_en,
  output logic [IDW-1:0]          wr_idx,
  output logic                    fin_vld,
  output logic [IDW-1:0]          fin_agent,
  output logic [CODE_W-1:0]       fin_code
);

  localparam int SPAN = 2 ** IDW;

  seq_st_e          st_q, st_d;
  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic [IDW-1:0]   agent_q, agent_d;
  logic [IDW-1:0]   tgt_q, tgt_d;
  logic             ctx_en;
  logic             any_grant;
  logic [IDW-1:0]   g_agent;
  logic [IDW-1:0]   g_tgt;
  logic [TMO_W-1:0] g_tmo;
  logic [SPAN-1:0]  ack_ext;

  always_comb begin
    any_grant = |grant;
    g_agent   = '0;
    g_tgt     = '0;
    g_tmo     = '0;
    for (int j = 0; j < N_CORE; j++) begin
      if (grant[j]) begin
        g_agent = IDW'(j);
        g_tgt   = req_tgt[j*IDW +: IDW];
        g_tmo   = req_tmo[j*TMO_W +: TMO_W];
      end
    end
    ack_ext = SPAN'(ack_q);
  end

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    agent_d   = agent_q;
    tgt_d     = tgt_q;
    ctx_en    = 1'b0;
    wr_en     = 1'b0;
    wr_idx    = g_tgt;
    fin_vld   = 1'b0;
    fin_agent = agent_q;
    fin_code  = ST_OK;
    unique case (st_q)
      S_IDLE: begin
        if (any_grant) begin
          fin_agent = g_agent;
          if (ack_ext[g_tgt]) begin
            fin_vld  = 1'b1;
            fin_code = ST_ALREADY;
          end else begin
            wr_en = 1'b1;
            if (g_tmo == '0) begin
              fin_vld  = 1'b1;
              fin_code = ST_OK;
            end else begin
              st_d    = S_WAIT;
              cnt_d   = g_tmo;
              agent_d = g_agent;
              tgt_d   = g_tgt;
              ctx_en  = 1'b1;
            end
          end
        end
      end
      S_WAIT: begin
        if (ack_ext[tgt_q]) begin
          fin_vld  = 1'b1;
          fin_code = ST_OK;
          st_d     = S_IDLE;
        end else if (cnt_q == TMO_W'(1)) begin
          fin_vld  = 1'b1;
          fin_code = ST_TMO;
          st_d     = S_IDLE;
        end else begin
          cnt_d = cnt_q - TMO_W'(1);
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      agent_q <= '0;
      tgt_q   <= '0;
    end else if (ctx_en) begin
      agent_q <= agent_d;
      tgt_q   <= tgt_d;
    end
  end

  always_comb busy = (st_q == S_WAIT);

endmodule

// File: rtl/core_halt_ctl.sv
module core_halt_ctl
  import core_halt_pkg::*;
#(
  parameter int                N_CORE      = 4,
  parameter int                TMO_W       = 32,
  parameter logic [N_CORE-1:0] DBG_PRESENT = '1,
  parameter logic [31:0]       WRAP_RST    = 32'h0000_000F
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [N_CORE-1:0]              req_vld,
  input  logic [N_CORE*$clog2(N_CORE+1)-1:0] req_tgt,
  input  logic [N_CORE*TMO_W-1:0]        req_tmo,
  input  logic [N_CORE-1:0]              core_ack,
  output logic [N_CORE-1:0]              done,
  output logic [N_CORE*4-1:0]            status,
  output logic [N_CORE*32-1:0]           wrap_word
);

  localparam int IDW = $clog2(N_CORE + 1);

  logic [N_CORE-1:0]        grant;
  logic [N_CORE-1:0]        rej_vld;
  logic [N_CORE*CODE_W-1:0] rej_code;
  logic [IDW-1:0]           own_id;
  logic                     busy;
  logic                     wr_en;
  logic [IDW-1:0]           wr_idx;
  logic                     fin_vld;
  logic [IDW-1:0]           fin_agent;
  logic [CODE_W-1:0]        fin_code;
  logic [N_CORE-1:0]        ack_q;
  logic [N_CORE-1:0]        done_q, done_d;
  logic [N_CORE*CODE_W-1:0] stat_q, stat_d;

  halt_own_arb #(
    .N_CORE(N_CORE), .IDW(IDW), .DBG_PRESENT(DBG_PRESENT)
  ) u_arb (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_tgt(req_tgt),
    .busy(busy), .grant(grant), .rej_vld(rej_vld), .rej_code(rej_code),
    .own_id(own_id)
  );

  halt_seq #(
    .N_CORE(N_CORE), .IDW(IDW), .TMO_W(TMO_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .grant(grant), .req_tgt(req_tgt),
    .req_tmo(req_tmo), .ack_q(ack_q), .busy(busy), .wr_en(wr_en),
    .wr_idx(wr_idx), .fin_vld(fin_vld), .fin_agent(fin_agent),
    .fin_code(fin_code)
  );

  halt_wrap_bank #(
    .N_CORE(N_CORE), .IDW(IDW), .WRAP_RST(WRAP_RST)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .core_ack(core_ack), .wr_en(wr_en),
    .wr_idx(wr_idx), .ack_q(ack_q), .word(wrap_word)
  );

  always_comb begin
    for (int j = 0; j < N_CORE; j++) begin
      if (rej_vld[j]) begin
        done_d[j]                  = 1'b1;
        stat_d[j*CODE_W +: CODE_W] = rej_code[j*CODE_W +: CODE_W];
      end else if (fin_vld && (fin_agent == IDW'(j))) begin
        done_d[j]                  = 1'b1;
        stat_d[j*CODE_W +: CODE_W] = fin_code;
      end else begin
        done_d[j]                  = 1'b0;
        stat_d[j*CODE_W +: CODE_W] = stat_q[j*CODE_W +: CODE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= '0;
      stat_q <= '0;
    end else begin
      done_q <= done_d;
      stat_q <= stat_d;
    end
  end

  always_comb begin
    done   = done_q;
    status = stat_q;
  end

endmodule

// File: rtl/halt_ctl_chk.sv
module halt_ctl_chk
  import core_halt_pkg::*;
#(
  parameter int N_CORE = 4,
  parameter int IDW    = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [N_CORE-1:0]       core_ack,
  input logic [N_CORE-1:0]       grant,
  input logic [IDW-1:0]          own_id,
  input logic [N_CORE-1:0]       done,
  input logic [N_CORE*4-1:0]     status,
  input logic [N_CORE*32-1:0]    wrap_word
);

  localparam logic [IDW-1:0] UNOWNED  = '1;
  localparam logic [31:0]    ACK_MASK = 32'(1) << ACK_BIT;

  AST_OWNER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (own_id != UNOWNED) |=> $stable(own_id)); // R5

  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R6

  genvar k;
  generate
    for (k = 0; k < N_CORE; k++) begin : g_ast
      AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        done[k] |-> (status[k*4 +: 4] == ST_OK || status[k*4 +: 4] == ST_ALREADY ||
                     status[k*4 +: 4] == ST_UNSUP || status[k*4 +: 4] == ST_SELF ||
                     status[k*4 +: 4] == ST_OWNED || status[k*4 +: 4] == ST_TMO)); // R1

      AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(wrap_word[k*32 + HALT_BIT])); // R2

      AST_ACK_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_word[k*32 + ACK_BIT] == $past(core_ack[k])); // R2

      AST_WRITE_HALT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ((wrap_word[k*32 +: 32] & ~ACK_MASK) != ($past(wrap_word[k*32 +: 32]) & ~ACK_MASK))
        |-> ((wrap_word[k*32 +: 32] & ~ACK_MASK) == HALT_ONLY)); // R8
    end
  endgenerate

endmodule

bind core_halt_ctl halt_ctl_chk #(.N_CORE(N_CORE), .IDW(IDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_ack(core_ack), .grant(grant),
  .own_id(own_id), .done(done), .status(status), .wrap_word(wrap_word)
);

// File: tb/sim_core_halt_ctl.sv
module sim_core_halt_ctl;
  import core_halt_pkg::*;

  localparam int N   = 4;
  localparam int IDW = 3;
  localparam int TW  = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n;
  logic [N-1:0]      req_vld;
  logic [N*IDW-1:0]  req_tgt;
  logic [N*TW-1:0]   req_tmo;
  logic [N-1:0]      core_ack;
  logic [N-1:0]      done;
  logic [N*4-1:0]    status;
  logic [N*32-1:0]   wrap_word;

  core_halt_ctl #(
    .N_CORE(N), .TMO_W(TW), .DBG_PRESENT(4'b0111), .WRAP_RST(32'h0000_000F)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_tgt(req_tgt),
    .req_tmo(req_tmo), .core_ack(core_ack), .done(done), .status(status),
    .wrap_word(wrap_word)
  );

  typedef struct {
    int          agent;
    logic [3:0]  code;
    string       req;
  } exp_t;

  exp_t sb[$];
  int   n_chk = 0;
  int   n_bad = 0;
  int   cyc   = 0;
  bit   closed = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic close_run();
    if (!closed) begin
      closed = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic set_req(input int a, input int t, input int tmo);
    req_vld[a]               = 1'b1;
    req_tgt[a*IDW +: IDW]    = IDW'(t);
    req_tmo[a*TW +: TW]      = TW'(tmo);
  endtask

  task automatic expect_res(input int a, input logic [3:0] c, input string r);
    exp_t e;
    e.agent = a;
    e.code  = c;
    e.req   = r;
    sb.push_back(e);
  endtask

  task automatic pulse();
    @(negedge clk);
    req_vld = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expected results as done pulses appear
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < N; i++) begin
        if (done[i]) begin
          if (sb.size() == 0) begin
            check(1'b0, "R11 unexpected result", {28'(i), status[i*4 +: 4]}, 32'hFFFF_FFFF);
          end else begin
            exp_t e;
            e = sb.pop_front();
            check((e.agent == i) && (e.code == status[i*4 +: 4]), e.req,
                  {28'(i), status[i*4 +: 4]}, {28'(e.agent), e.code});
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !closed) begin
      check(1'b0, "watchdog", 32'(cyc), 32'd20000);
      close_run();
    end
  end

  initial begin
    int k;
    rst_n    = 1'b0;
    req_vld  = '0;
    req_tgt  = '0;
    req_tmo  = '0;
    core_ack = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // reset state
    check(done == '0, "R1 reset done", 32'(done), 32'h0);
    for (int t = 0; t < N; t++)
      check(wrap_word[t*32 +: 32] == 32'h0000_000F, "R2 reset word",
            wrap_word[t*32 +: 32], 32'h0000_000F);

    // unsupported target
    set_req(1, 3, 0); expect_res(1, ST_UNSUP, "R3"); pulse(); idle(2);
    check(wrap_word[3*32 +: 32] == 32'h0000_000F, "R3 no write", wrap_word[3*32 +: 32], 32'h0000_000F);

    // self halt
    set_req(1, 1, 0); expect_res(1, ST_SELF, "R4"); pulse(); idle(2);
    check(wrap_word[1*32 +: 32] == 32'h0000_000F, "R4 no write", wrap_word[1*32 +: 32], 32'h0000_000F);

    // simultaneous claim, zero timeout
    set_req(2, 0, 0); set_req(1, 0, 0);
    expect_res(1, ST_OK, "R6"); expect_res(2, ST_OWNED, "R6");
    pulse();
    check(done[1] == 1'b1, "R9 zero-timeout latency", 32'(done[1]), 32'h1);
    idle(1);
    check(wrap_word[0 +: 32] == 32'h8000_0000, "R8 halt write", wrap_word[0 +: 32], 32'h8000_0000);

    // later requester with lower index is still refused
    set_req(0, 1, 0); expect_res(0, ST_OWNED, "R5"); pulse(); idle(2);

    // already halted
    core_ack[2] = 1'b1; idle(2);
    check(wrap_word[2*32 +: 32] == 32'h1000_000F, "R2 ack bit", wrap_word[2*32 +: 32], 32'h1000_000F);
    set_req(1, 2, 9); expect_res(1, ST_ALREADY, "R7"); pulse(); idle(2);
    check(wrap_word[2*32 +: 32] == 32'h1000_000F, "R7 no write", wrap_word[2*32 +: 32], 32'h1000_000F);

    // timeout with ignored owner request mid-wait
    core_ack[2] = 1'b0; idle(2);
    set_req(1, 2, 5); expect_res(1, ST_TMO, "R10"); pulse();
    k = 1;
    while (!done[1] && k < 60) begin
      if (k == 2) set_req(1, 0, 0);   // R11: must be ignored
      @(negedge clk);
      req_vld = '0;
      k++;
    end
    check(k == 6, "R10 timeout latency", 32'(k), 32'd6);
    check(wrap_word[2*32 +: 32] == 32'h8000_0000, "R8 halt write", wrap_word[2*32 +: 32], 32'h8000_0000);
    idle(3);

    // success on acknowledge within window
    set_req(1, 0, 20); expect_res(1, ST_OK, "R10"); pulse();
    idle(3);
    core_ack[0] = 1'b1;
    idle(4);
    check(wrap_word[0 +: 32] == 32'h9000_0000, "R2 halted word", wrap_word[0 +: 32], 32'h9000_0000);

    idle(5);
    check(sb.size() == 0, "R11 results outstanding", 32'(sb.size()), 32'h0);
    close_run();
  end

endmodule